// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block watches a key matrix of up to eight drive lines and eight sense lines and reports which keys are held, for any mix of keys up to all 64 at once. While nothing is pressed, every drive line stays high, so one key closure on any line shows up on the sense inputs. When that happens, the block steps a single high drive line across the rows. Each row is held long enough for the lines to settle, and the block collects one full 64-bit picture of the matrix per pass.

A new picture is only accepted when a programmable number of back-to-back passes agree on it. The accepted picture is placed on a 64-bit key-state output, and a sticky interrupt is raised each time that state changes. The interrupt is cleared by a one-cycle clear pulse. Scanning goes on after the first press, so extra presses and releases are tracked. Once an all-released picture has been accepted, the block goes back to the all-rows-high idle state. A wake output is high whenever the scanner is active, and a power controller can use it to bring the processor out of a low-power mode.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, all row outputs are high, the key state is all zero, and irq and wake are low.
- R2: While idle, all row outputs are high and wake is low. The block stays idle until a synchronized column input goes high.
- R3: After column activity is seen in idle, wake goes high and exactly one row output is high at any time until the block returns to idle.
- R4: Each row is driven for settle_cycles+1 clocks, and its columns are sampled on the last of those clocks (settle_cycles must be at least 2, to cover the two-flop column synchronizer). The key at row r, column c is reported at key_state bit r*8+c.
- R5: Any combination of pressed keys, including all 64, is reported exactly.
- R6: key_state only takes a new value after debounce_scans consecutive complete scans have returned that same value. A debounce_scans value of 0 acts as 1. A press seen in fewer scans is never reported.
- R7: irq is sticky. Once set, it stays high until a cycle with irq_clear high and no new state update.
- R8: Every change of key_state sets irq in the same clock, including changes caused by extra presses and by releases during continuous scanning.
- R9: After an all-released state has been debounced, the block returns to idle with all rows high and wake low.
- R10: When a key_state update and irq_clear fall in the same clock, the update wins and irq is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_in | input | 8 | Matrix sense lines, high when a key on the driven row is closed |
| settle_cycles | input | 8 | Extra clocks each row is held before its columns are sampled |
| debounce_scans | input | 4 | Number of identical consecutive full scans needed to accept a new state |
| irq_clear | input | 1 | One-cycle pulse that clears the sticky interrupt |
| row_out | output | 8 | Matrix drive lines |
| key_state | output | 64 | Debounced key picture, bit r*8+c for row r, column c |
| irq | output | 1 | Sticky interrupt, set whenever key_state changes |
| wake | output | 1 | High while the scanner is out of idle |

## Verification
A new debounced state sets the interrupt, while software may be clearing it in the same clock. These two can collide. The bench provokes the collision by holding irq_clear high for the whole time a key press is being debounced, so the clear is present in exactly the clock where key_state changes. It samples irq in the half cycle after key_state first changes and expects it high. In the following cycle, where only the clear remains, it expects irq low.

// File: rtl/kp_pkg.sv
// Package: shared types for the keypad scanner.
// Assumes nothing beyond being compiled first.
package kp_pkg;
    typedef enum logic {
        SCN_IDLE   = 1'b0,
        SCN_ACTIVE = 1'b1
    } scan_state_t;
endpackage

// File: rtl/kp_col_sync.sv
// Two-flop synchronizer for the column sense lines.
// Assumes the column inputs are asynchronous to clk and quasi-static.
module kp_col_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the raw column lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign q_out = sync_q;
endmodule

// File: rtl/kp_row_scanner.sv
// Row drive sequencer: it idles with every row high and waits for column
// activity. It then walks a single high row across the matrix, holding
// each row for settle+1 clocks, and builds one full scan word per pass.
// Assumes settle >= 2 so the synchronized columns reflect the driven row.
module kp_row_scanner
    import kp_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COLS-1:0]      col_s,
    input  logic [SETTLE_W-1:0]  settle,
    input  logic                 go_idle,
    output logic [ROWS-1:0]      row_out,
    output logic [ROWS*COLS-1:0] scan_word,
    output logic                 scan_done,
    output logic                 active
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int KEYS  = ROWS * COLS;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    scan_state_t         state_q;
    logic [ROW_W-1:0]    row_q;
    logic [SETTLE_W-1:0] hold_q;
    logic [KEYS-1:0]     buf_q;
    logic                sample;

    assign sample    = (state_q == SCN_ACTIVE) && (hold_q == settle);
    assign scan_done = sample && (row_q == LAST_ROW);
    assign active    = (state_q == SCN_ACTIVE);

    // Drive a single row while scanning, all rows while idle.
    always_comb begin
        if (state_q == SCN_ACTIVE) begin
            row_out        = '0;
            row_out[row_q] = 1'b1;
        end else begin
            row_out = '1;
        end
    end

    // The full scan word uses the stored rows plus the live last row.
    for (genvar r = 0; r < ROWS; r++) begin : g_word
        if (r == ROWS - 1) begin : g_live
            assign scan_word[r*COLS +: COLS] = col_s;
        end else begin : g_held
            assign scan_word[r*COLS +: COLS] = buf_q[r*COLS +: COLS];
        end
    end

    // Sequencer state, row index and per-row hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCN_IDLE;
            row_q   <= '0;
            hold_q  <= '0;
        end else if (state_q == SCN_IDLE) begin
            row_q  <= '0;
            hold_q <= '0;
            if (|col_s) state_q <= SCN_ACTIVE;
        end else if (sample) begin
            hold_q <= '0;
            if (row_q == LAST_ROW) begin
                row_q <= '0;
                if (go_idle) state_q <= SCN_IDLE;
            end else begin
                row_q <= row_q + 1'b1;
            end
        end else begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // Capture the sampled columns of the current row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (sample) begin
            buf_q[row_q*COLS +: COLS] <= col_s;
        end
    end
endmodule

// File: rtl/kp_debounce.sv
// Debounce and reporting: it accepts a scan word once the required number
// of consecutive complete scans agree on it. It updates the key state,
// raises the sticky interrupt, and requests idle on a stable empty matrix.
// Assumes scan_done is a one-cycle strobe with scan_word valid alongside.
module kp_debounce #(
    parameter int KEYS  = 64,
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_done,
    input  logic [KEYS-1:0]  scan_word,
    input  logic [DEB_W-1:0] need_scans,
    input  logic             irq_clear,
    output logic [KEYS-1:0]  key_state,
    output logic             irq,
    output logic             go_idle
);
    localparam logic [DEB_W-1:0] CNT_MAX = '1;

    logic [KEYS-1:0]  cand_q;
    logic [KEYS-1:0]  state_q;
    logic [DEB_W-1:0] match_q;
    logic [DEB_W-1:0] match_nx;
    logic [DEB_W-1:0] need_eff;
    logic             stable;
    logic             commit;
    logic             irq_q;

    // Agreement count for this scan and the commit decision.
    always_comb begin
        need_eff = (need_scans == '0) ? DEB_W'(1) : need_scans;
        if (scan_word == cand_q)
            match_nx = (match_q == CNT_MAX) ? match_q : match_q + 1'b1;
        else
            match_nx = DEB_W'(1);
        stable  = (match_nx >= need_eff);
        commit  = scan_done && stable && (scan_word != state_q);
        go_idle = scan_done && stable && (scan_word == '0);
    end

    // Candidate tracking and stored key state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q  <= '0;
            match_q <= '0;
            state_q <= '0;
        end else if (scan_done) begin
            cand_q  <= scan_word;
            match_q <= match_nx;
            if (commit) state_q <= scan_word;
        end
    end

    // Sticky interrupt; a new update takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (commit)    irq_q <= 1'b1;
        else if (irq_clear) irq_q <= 1'b0;
    end

    assign key_state = state_q;
    assign irq       = irq_q;
endmodule

// File: rtl/keypad_scanner.sv
// Keypad scanner top: column synchronizer, row sequencer and debounce.
// Assumes settle_cycles >= 2 and quasi-static configuration inputs.
module keypad_scanner #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int SETTLE_W = 8,
    parameter int DEB_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COLS-1:0]      col_in,
    input  logic [SETTLE_W-1:0]  settle_cycles,
    input  logic [DEB_W-1:0]     debounce_scans,
    input  logic                 irq_clear,
    output logic [ROWS-1:0]      row_out,
    output logic [ROWS*COLS-1:0] key_state,
    output logic                 irq,
    output logic                 wake
);
    localparam int KEYS = ROWS * COLS;

    logic [COLS-1:0] col_s;
    logic [KEYS-1:0] scan_word;
    logic            scan_done;
    logic            go_idle;

    kp_col_sync #(.WIDTH(COLS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (col_in),
        .q_out (col_s)
    );

    kp_row_scanner #(.ROWS(ROWS), .COLS(COLS), .SETTLE_W(SETTLE_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_s     (col_s),
        .settle    (settle_cycles),
        .go_idle   (go_idle),
        .row_out   (row_out),
        .scan_word (scan_word),
        .scan_done (scan_done),
        .active    (wake)
    );

    kp_debounce #(.KEYS(KEYS), .DEB_W(DEB_W)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_done  (scan_done),
        .scan_word  (scan_word),
        .need_scans (debounce_scans),
        .irq_clear  (irq_clear),
        .key_state  (key_state),
        .irq        (irq),
        .go_idle    (go_idle)
    );
endmodule

// File: rtl/kp_scanner_checker.sv
// Checker bound to keypad_scanner: it watches the ports for row drive
// rules, row hold time and interrupt behaviour.
// Assumes a synchronous active-low reset.
module kp_scanner_checker #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int SETTLE_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SETTLE_W-1:0]  settle_cycles,
    input logic                 irq_clear,
    input logic [ROWS-1:0]      row_out,
    input logic [ROWS*COLS-1:0] key_state,
    input logic                 irq,
    input logic                 wake
);
    logic [ROWS-1:0]   prev_row;
    logic [SETTLE_W:0] hold_len;

    // Count how many clocks the current row pattern has been visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_row <= '1;
            hold_len <= '0;
        end else begin
            prev_row <= row_out;
            hold_len <= (row_out != prev_row) ? (SETTLE_W+1)'(1) : hold_len + 1'b1;
        end
    end

    assert_idle_rows_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |-> (row_out == '1));

    assert_single_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $onehot(row_out));

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && (row_out != prev_row) && (prev_row != '1))
        |-> (hold_len == ({1'b0, settle_cycles} + 1'b1)));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    assert_update_sets_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state != $past(key_state)) |-> irq);
endmodule

bind keypad_scanner kp_scanner_checker #(
    .ROWS(ROWS), .COLS(COLS), .SETTLE_W(SETTLE_W)
) u_kp_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .settle_cycles (settle_cycles),
    .irq_clear     (irq_clear),
    .row_out       (row_out),
    .key_state     (key_state),
    .irq           (irq),
    .wake          (wake)
);

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  col_in;
    logic [7:0]  settle_cycles = 8'd3;
    logic [3:0]  debounce_scans = 4'd3;
    logic        irq_clear = 1'b0;
    logic [7:0]  row_out;
    logic [63:0] key_state;
    logic        irq;
    logic        wake;
    logic [63:0] keys = '0;   // bit r*8+c: key at row r, column c is closed

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    keypad_scanner dut (
        .clk(clk), .rst_n(rst_n), .col_in(col_in),
        .settle_cycles(settle_cycles), .debounce_scans(debounce_scans),
        .irq_clear(irq_clear), .row_out(row_out), .key_state(key_state),
        .irq(irq), .wake(wake)
    );

    // Matrix model: a closed key connects its row line to its column line.
    always_comb begin
        col_in = '0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (row_out[r] && keys[r*8+c]) col_in[c] = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        check(irq == 1'b1, req, {63'd0, irq}, 64'd1);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (wake && n < 3000) begin @(negedge clk); n++; end
        check(wake == 1'b0 && row_out == 8'hFF, req, {55'd0, wake, row_out}, 64'h0FF);
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(row_out == 8'hFF && key_state == '0 && !irq && !wake, "R1 reset",
              {key_state[31:0], 14'd0, irq, wake, 8'd0, row_out}, 64'hFF);
    endtask

    task automatic t_idle();
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(row_out == 8'hFF && !wake, "R2 idle rows high", {55'd0, wake, row_out}, 64'hFF);
    endtask

    task automatic t_single_key();
        int hold = 0;
        logic [7:0] r0;
        keys = 64'd1 << 21;   // row 2, column 5
        repeat (6) @(negedge clk);
        check(wake && $onehot(row_out), "R3 scanning one row", {55'd0, wake, row_out}, 64'h101);
        r0 = row_out;
        while (row_out == r0) @(negedge clk);
        r0 = row_out;
        while (row_out == r0) begin @(negedge clk); hold++; end
        check(hold == 4, "R4 row hold", 64'(hold), 64'd4);
        wait_irq("R8 irq on press");
        check(key_state == (64'd1 << 21), "R4 key bit position", key_state, 64'd1 << 21);
        repeat (50) @(negedge clk);
        check(irq == 1'b1, "R7 irq sticky", {63'd0, irq}, 64'd1);
        clear_irq();
        check(irq == 1'b0, "R7 irq cleared", {63'd0, irq}, 64'd0);
        keys = '0;
        wait_irq("R8 irq on release");
        check(key_state == '0, "R8 release stored", key_state, 64'd0);
        wait_idle("R9 back to idle");
        clear_irq();
    endtask

    task automatic t_glitch();
        keys = 64'd1 << 3;
        repeat (20) @(negedge clk);
        keys = '0;
        repeat (400) @(negedge clk);
        check(irq == 1'b0 && key_state == '0, "R6 short press rejected", key_state, 64'd0);
        check(row_out == 8'hFF && !wake, "R9 idle after glitch", {55'd0, wake, row_out}, 64'hFF);
    endtask

    task automatic t_extra_and_release();
        logic [63:0] a = 64'd1 << 10, b = 64'd1 << 55;
        keys = a;
        wait_irq("R8 first key");
        clear_irq();
        keys = a | b;
        wait_irq("R8 extra key irq");
        check(key_state == (a | b), "R8 extra key state", key_state, a | b);
        clear_irq();
        keys = b;
        wait_irq("R8 partial release irq");
        check(key_state == b, "R8 partial release state", key_state, b);
        check(wake == 1'b1, "R9 still scanning with key held", {63'd0, wake}, 64'd1);
        clear_irq();
        keys = '0;
        wait_irq("R8 full release");
        wait_idle("R9 idle after release");
        clear_irq();
    endtask

    task automatic t_pattern(input logic [63:0] pat, input string req);
        keys = pat;
        wait_irq(req);
        check(key_state == pat, req, key_state, pat);
        clear_irq();
        keys = '0;
        wait_irq(req);
        wait_idle("R9 idle after pattern");
        clear_irq();
    endtask

    task automatic t_set_vs_clear();
        int n = 0;
        irq_clear = 1'b1;
        keys = 64'd1 << 40;
        while (key_state == '0 && n < 3000) begin @(negedge clk); n++; end
        check(irq == 1'b1, "R10 update beats clear", {63'd0, irq}, 64'd1);
        @(negedge clk);
        check(irq == 1'b0, "R10 clear next cycle", {63'd0, irq}, 64'd0);
        irq_clear = 1'b0;
        keys = '0;
        wait_irq("R10 release");
        wait_idle("R9 idle after R10");
        clear_irq();
    endtask

    task automatic t_debounce_zero();
        debounce_scans = 4'd0;
        keys = 64'd1 << 63;
        wait_irq("R6 zero acts as one");
        check(key_state == (64'd1 << 63), "R6 zero acts as one", key_state, 64'd1 << 63);
        clear_irq();
        keys = '0;
        wait_irq("R6 zero release");
        wait_idle("R9 idle after R6");
        clear_irq();
        debounce_scans = 4'd3;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_single_key();
        t_glitch();
        t_extra_and_release();
        t_pattern(64'hFFFF_FFFF_FFFF_FFFF, "R5 all 64 keys");
        t_pattern(64'h8040_2010_0804_0201, "R5 diagonal");
        t_pattern(64'hA5A5_0000_FF00_0081, "R5 mixed pattern");
        t_set_vs_clear();
        t_debounce_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule